// File: doc/BRIEF.md
# Bit-Serial Machine Cycle Sequencer

This block paces a 32-bit bit-serial processor. A synchronous counter runs through the clock phases of one machine cycle, one phase per master clock, so one data bit is handled in each phase. Several kinds of machine cycle are supported: a normal cycle, a short and a long cycle for front-panel operations, and a dedicated cycle used to enter an interrupt context.

Requests for a special cycle are plain levels. They are sampled only in the closing phase of the current cycle, and the chosen type takes effect at the next phase 0. The sequencer brings out the phase number, the active cycle type, start and end strobes, and two blanking controls. Each blanking control is meant to be ORed with the bit clock or the memory clock, so that a blanked clock stays at its inactive high level.

Top module: `mcyc_sequencer`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the sequencer goes to phase 0 of a normal cycle (`cyc_type` = 0) with `cyc_start` high. Reset is synchronous and has priority over everything else.
- R2: Within a cycle, `phase` rises by exactly one on each clock. In the long cycle it wraps from 31 back to 0 once without ending the cycle.
- R3: The cycles last 32 clocks for normal, 8 for front-panel short, 64 for front-panel long and 32 for interrupt entry.
- R4: `cyc_end` is high only in the final clock of a cycle. `cyc_start` is high only in the first clock of a cycle, and so is low in the second pass through phase 0 of a long cycle.
- R5: Request inputs are sampled only in the clock where `cyc_end` is high. A request raised and dropped at any other time has no effect on the next cycle type.
- R6: When several requests are sampled together, interrupt entry wins over long, and long wins over short. With no request, the next cycle is normal.
- R7: `cyc_type` encodes 0 = normal, 1 = short, 2 = long, 3 = interrupt entry. It changes only on the clock that follows a `cyc_end`.
- R8: `bit_clk_blank` is high exactly during short cycles.
- R9: `mem_clk_blank` is high exactly during interrupt-entry cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Request an interrupt-entry cycle |
| fp_long_req | input | 1 | Request a front-panel long cycle |
| fp_short_req | input | 1 | Request a front-panel short cycle |
| phase | output | 5 | Current phase within the 32-phase frame |
| cyc_type | output | 2 | Active cycle type (see R7) |
| cyc_start | output | 1 | First clock of a cycle |
| cyc_end | output | 1 | Last clock of a cycle |
| bit_clk_blank | output | 1 | Hold bit clock high (ORed with the clock) |
| mem_clk_blank | output | 1 | Hold memory clock high (ORed with the clock) |

## Verification
Two events can fall in the same clock: the end phase of a cycle, where the type arbiter loads a new type and the counter returns to zero, and a reset or a request that arrives in that same clock. The bench holds requests across the end phase, in every combination, and then judges the type, the length and the blanking of the cycle that follows. It also pulses a request away from the end phase and asserts reset in the middle of a long cycle, and in each case checks that only the sampled event shapes the next phase 0.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [1:0] {
    CT_NORM  = 2'd0,
    CT_SHORT = 2'd1,
    CT_LONG  = 2'd2,
    CT_IRQ   = 2'd3
  } cyc_t;

  // Number of clocks in a cycle of the given type.
  function automatic int unsigned cyc_len(cyc_t t, int unsigned norm_len,
                                          int unsigned short_len, int unsigned long_len);
    case (t)
      CT_SHORT: return short_len;
      CT_LONG:  return long_len;
      default:  return norm_len;
    endcase
  endfunction

  // Fixed-priority choice of the next cycle type.
  function automatic cyc_t cyc_pick(logic irq, logic lng, logic shrt);
    if (irq)       return CT_IRQ;
    else if (lng)  return CT_LONG;
    else if (shrt) return CT_SHORT;
    else           return CT_NORM;
  endfunction

endpackage

// File: rtl/mcyc_counter.sv
module mcyc_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] last_idx,
  output logic [CW-1:0] cnt,
  output logic          at_last,
  output logic          at_first
);
  assign at_last  = (cnt == last_idx);
  assign at_first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mcyc_type_sel.sv
module mcyc_type_sel
  import mcyc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic irq_req,
  input  logic fp_long_req,
  input  logic fp_short_req,
  output cyc_t cur_type
);
  cyc_t next_type;
  assign next_type = cyc_pick(irq_req, fp_long_req, fp_short_req);

  always_ff @(posedge clk) begin
    if (rst)          cur_type <= CT_NORM;
    else if (advance) cur_type <= next_type;
  end
endmodule

// File: rtl/mcyc_clk_gate.sv
module mcyc_clk_gate
  import mcyc_pkg::*;
#(
  parameter int NGATE = 2
) (
  input  cyc_t             cur_type,
  output logic [NGATE-1:0] blank
);
  // Entry g names the cycle type that blanks clock g (0: bit, 1: memory).
  localparam cyc_t BLANK_ON [2] = '{CT_SHORT, CT_IRQ};

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    assign blank[g] = (cur_type == BLANK_ON[g]);
  end
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
  import mcyc_pkg::*;
#(
  parameter int PHASE_W   = 5,
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_req,
  input  logic               fp_long_req,
  input  logic               fp_short_req,
  output logic [PHASE_W-1:0] phase,
  output logic [1:0]         cyc_type,
  output logic               cyc_start,
  output logic               cyc_end,
  output logic               bit_clk_blank,
  output logic               mem_clk_blank
);
  localparam int NORM_LEN = 1 << PHASE_W;
  localparam int CW       = $clog2(LONG_LEN);

  cyc_t          cur_type;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic          at_last;
  logic          at_first;
  logic [1:0]    blank;

  assign last_idx = CW'(cyc_len(cur_type, NORM_LEN, SHORT_LEN, LONG_LEN) - 1);

  mcyc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .last_idx(last_idx),
    .cnt(cnt), .at_last(at_last), .at_first(at_first)
  );

  mcyc_type_sel u_type (
    .clk(clk), .rst(rst), .advance(at_last),
    .irq_req(irq_req), .fp_long_req(fp_long_req), .fp_short_req(fp_short_req),
    .cur_type(cur_type)
  );

  mcyc_clk_gate #(.NGATE(2)) u_gate (
    .cur_type(cur_type), .blank(blank)
  );

  assign phase         = cnt[PHASE_W-1:0];
  assign cyc_type      = cur_type;
  assign cyc_start     = at_first;
  assign cyc_end       = at_last;
  assign bit_clk_blank = blank[0];
  assign mem_clk_blank = blank[1];
endmodule

// File: rtl/mcyc_sequencer_chk.sv
module mcyc_sequencer_chk #(
  parameter int PHASE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_req,
  input logic               fp_long_req,
  input logic               fp_short_req,
  input logic [PHASE_W-1:0] phase,
  input logic [1:0]         cyc_type,
  input logic               cyc_start,
  input logic               cyc_end,
  input logic               bit_clk_blank,
  input logic               mem_clk_blank
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == '0 && cyc_type == 2'd0 && cyc_start));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> phase == $past(phase) + 1'b1);

  a_r4_end_restarts: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> (phase == '0 && cyc_start));

  a_r4_start_not_end: assert property (@(posedge clk) disable iff (rst)
    !(cyc_start && cyc_end));

  a_r7_type_stable: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(cyc_type));

  a_r6_irq_wins: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && irq_req) |=> cyc_type == 2'd3);

  a_r6_long_over_short: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !irq_req && fp_long_req) |=> cyc_type == 2'd2);

  a_r6_short_alone: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !irq_req && !fp_long_req && fp_short_req) |=> cyc_type == 2'd1);

  a_r8_bit_blank: assert property (@(posedge clk) disable iff (rst)
    bit_clk_blank == (cyc_type == 2'd1));

  a_r9_mem_blank: assert property (@(posedge clk) disable iff (rst)
    mem_clk_blank == (cyc_type == 2'd3));
endmodule

bind mcyc_sequencer mcyc_sequencer_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .fp_long_req(fp_long_req),
  .fp_short_req(fp_short_req), .phase(phase), .cyc_type(cyc_type),
  .cyc_start(cyc_start), .cyc_end(cyc_end),
  .bit_clk_blank(bit_clk_blank), .mem_clk_blank(mem_clk_blank)
);

// File: tb/mcyc_sequencer_test.sv
module mcyc_sequencer_test;
  logic       clk = 1'b0;
  logic       rst, irq_req, fp_long_req, fp_short_req;
  logic [4:0] phase;
  logic [1:0] cyc_type;
  logic       cyc_start, cyc_end, bit_clk_blank, mem_clk_blank;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  mcyc_sequencer uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .fp_long_req(fp_long_req),
    .fp_short_req(fp_short_req), .phase(phase), .cyc_type(cyc_type),
    .cyc_start(cyc_start), .cyc_end(cyc_end),
    .bit_clk_blank(bit_clk_blank), .mem_clk_blank(mem_clk_blank)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Request bits {irq, long, short}, expected type, expected length.
  localparam int NV = 10;
  localparam logic [2:0] V_REQ  [NV] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b111,
                                         3'b011, 3'b101, 3'b001, 3'b001, 3'b000};
  localparam int         V_TYPE [NV] = '{0, 1, 2, 3, 3, 2, 3, 1, 1, 0};
  localparam int         V_LEN  [NV] = '{32, 8, 64, 32, 32, 64, 32, 8, 8, 32};

  // Called at a negedge where cyc_end is high. Requests are held across the
  // sampling edge, then released. pulse_at >= 0 pulses irq at that clock
  // index inside the cycle (R5); rst_at >= 0 resets there (R1).
  task automatic run_cycle(logic [2:0] rq, int exp_t, int exp_len,
                           int pulse_at, int rst_at);
    int n;
    int len;
    {irq_req, fp_long_req, fp_short_req} = rq;
    @(negedge clk);
    {irq_req, fp_long_req, fp_short_req} = 3'b000;
    chk("R7 type", cyc_type, exp_t);
    chk("R4 start", cyc_start, 1);
    chk("R2 phase0", phase, 0);
    chk("R8 bit blank", bit_clk_blank, exp_t == 1);
    chk("R9 mem blank", mem_clk_blank, exp_t == 3);
    n = 0;
    len = exp_len;
    while (!cyc_end) begin
      @(negedge clk);
      n++;
      irq_req = (n == pulse_at);
      if (n == rst_at) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset phase", phase, 0);
        chk("R1 mid reset type", cyc_type, 0);
        chk("R1 mid reset start", cyc_start, 1);
        n = 0;
        len = 32;
      end else begin
        if (phase != n % 32) chk("R2 phase step", phase, n % 32);
        if (cyc_start) chk("R4 start only first", cyc_start, 0);
        if (cyc_type != (n == 0 ? 0 : (rst_at >= 0 ? 0 : exp_t)) && rst_at < 0)
          chk("R7 type stable", cyc_type, exp_t);
      end
      if (n > 80) break;
    end
    irq_req = 1'b0;
    chk("R3 length", n + 1, len);
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    irq_req = 1'b1;
    fp_long_req = 1'b1;
    fp_short_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 0);
    chk("R1 reset type", cyc_type, 0);
    chk("R1 reset start", cyc_start, 1);
    chk("R1 reset end", cyc_end, 0);
    irq_req = 1'b0;
    fp_long_req = 1'b0;
    rst = 1'b0;
    // First cycle after reset is normal: 31 more clocks to its end.
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      if (cyc_end != (i == 31)) chk("R4 end strobe", cyc_end, i == 31);
    end
    chk("R1 first cycle ends", cyc_end, 1);

    for (int v = 0; v < NV; v++)
      run_cycle(V_REQ[v], V_TYPE[v], V_LEN[v], -1, -1);

    // R5: irq pulsed mid-cycle, dropped before the end: next cycle normal.
    run_cycle(3'b000, 0, 32, 10, -1);
    run_cycle(3'b000, 0, 32, -1, -1);
    // R5: pulse during the last-but-one clock of a short cycle is ignored.
    run_cycle(3'b001, 1, 8, 6, -1);
    run_cycle(3'b000, 0, 32, -1, -1);
    // R1: reset in the middle of a long cycle.
    run_cycle(3'b010, 2, 64, -1, 40);
    run_cycle(3'b100, 3, 32, -1, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule